// File: doc/BRIEF.md
# Timer/Counter Channel with Prescaler

This block is one channel of a general-purpose 32-bit timer. It counts in one of two ways. In timer mode it steps on ticks from a 6-bit clock divider. In counter mode it steps on selected edges of an external input, after that input has been synchronized. The count can run upward from zero or downward from all-ones. When it reaches a programmable limit it wraps back to its start value. It then either keeps running (periodic) or stops (one-shot).

Two single-cycle strobes mark the moments the count arrives at the match value and at the limit value. Each strobe can latch a status bit if its enable is set. The interrupt line is the OR of the status bits, and a single clear pulse empties both of them.

A controlling block drives the configuration inputs and a run level. It restarts a finished one-shot by taking run low and then high again.

Top module: `tmr_channel`

## Requirements
- R1: In timer mode the count takes one step every PRESCALE+1 running clock cycles. With a prescale value of 0 it steps on every clock. The first step comes PRESCALE+1 clocks after the start cycle.
- R2: In up-count mode, a low-to-high change of run after reset loads 0. The count then steps +1 up to the limit, and the following step returns it to 0.
- R3: In down-count mode the start load is 0xFFFF_FFFF. The count steps -1 down to the limit, and the following step returns it to 0xFFFF_FFFF.
- R4: In periodic mode counting carries on after the wrap. In one-shot mode the wrapping step loads the start value and counting stops while run stays high. A later low-to-high change of run reloads the start value and counting resumes.
- R5: In counter mode the prescaler is bypassed, and each qualifying edge of the synchronized external input adds exactly one step. The edge select encoding is 2'b01 rising, 2'b10 falling, 2'b11 both, and 2'b00 none.
- R6: The match strobe is high for one cycle. That cycle is the one in which a step has just made the count equal to the match value.
- R7: The overflow strobe is high for one cycle. That cycle is the one in which a step has just made the count equal to the limit value, and this includes a wrap onto a limit of 0.
- R8: In up-count mode with the match value above the limit, no match strobe and no match status ever appear.
- R9: Status bit 0 (match) and bit 1 (overflow) are set by their strobe only when the matching enable bit is set. The interrupt line is the OR of the status bits. A clear pulse empties both bits, and an event in the same cycle wins.
- R10: While run is low the count and the prescaler hold their values. Raising run again resumes from the held count unless the channel is idle.
- R11: After reset the count is 0, both strobes are low, the status is 0 and the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run level; a rising change restarts an idle channel |
| cnt_mode_i | input | 1 | 0 = timer (prescaled clock), 1 = counter (external edges) |
| dir_down_i | input | 1 | 0 = up-count, 1 = down-count |
| one_shot_i | input | 1 | 0 = periodic, 1 = one-shot |
| edge_sel_i | input | 2 | Qualifying edge in counter mode |
| prescale_i | input | PRE_W | Clock divide value minus one |
| match_i | input | CNT_W | Match value |
| limit_i | input | CNT_W | Limit value |
| irq_en_i | input | 2 | Enables: bit 0 match, bit 1 overflow |
| irq_clr_i | input | 1 | Clears all status bits |
| ext_i | input | 1 | Asynchronous external count input |
| count_o | output | CNT_W | Current count |
| match_evt_o | output | 1 | Match strobe |
| ovf_evt_o | output | 1 | Overflow strobe |
| irq_status_o | output | 2 | Status: bit 0 match, bit 1 overflow |
| irq_o | output | 1 | Channel interrupt |

## Verification
The bench builds the block with the default widths: a 32-bit count, a 6-bit prescaler and two synchronizer stages. At full count width, down-count limits just below all-ones are reached within a few steps, so the wrap back to all-ones is checked directly. The 6-bit prescaler lets the largest divide of 64 be covered in about 130 cycles. The two-stage synchronizer fixes the latency of external edges at three clocks, and the bench waits past that latency before it samples.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // bit 1 overflow, bit 0 match: the same order as the status register
  typedef struct packed {
    logic ovf;
    logic match;
  } tmr_evt_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pc_q, pc_d;

  // >= so that lowering the divide value mid-count cannot stall a full wrap
  assign tick_o = en_i && (pc_q >= div_i);

  always_comb begin
    pc_d = pc_q;
    if (clr_i)       pc_d = '0;
    else if (tick_o) pc_d = '0;
    else if (en_i)   pc_d = pc_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R1: every tick restarts the divide period
  assert_tick_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (pc_q == '0));
  // R10: a disabled prescaler holds its phase
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(pc_q));
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync
  import tmr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ext_i,
  input  edge_sel_e sel_i,
  output logic      edge_o
);
  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], ext_i};
  end

  logic rise, fall;
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end

  // R5: a rising-edge report traces back to a high input STAGES clocks earlier
  assert_rise_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && sel_i == EDGE_RISE) |-> $past(ext_i, STAGES));
  assert_fall_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && sel_i == EDGE_FALL) |-> !$past(ext_i, STAGES));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tmr_evt_t   set_i,
  input  logic [1:0] en_i,
  input  logic       clr_i,
  output logic [1:0] status_o,
  output logic       irq_o
);
  logic [1:0] sts_q, sts_d, hits;

  assign hits = set_i & en_i;

  always_comb begin
    sts_d = clr_i ? 2'b00 : sts_q;
    sts_d = sts_d | hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign status_o = sts_q;
  assign irq_o    = |sts_q;

  // R9: a status bit only rises from an enabled event
  assert_match_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[0]) |-> $past(set_i.match && en_i[0]));
  assert_ovf_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[1]) |-> $past(set_i.ovf && en_i[1]));
  // R9: a clear with no concurrent event empties the status
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && hits == 2'b00) |=> (status_o == 2'b00 && !irq_o));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             cnt_mode_i,
  input  logic             dir_down_i,
  input  logic             one_shot_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [1:0]       irq_en_i,
  input  logic             irq_clr_i,
  input  logic             ext_i,
  output logic [CNT_W-1:0] count_o,
  output logic             match_evt_o,
  output logic             ovf_evt_o,
  output logic [1:0]       irq_status_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] UP_START   = '0;
  localparam logic [CNT_W-1:0] DOWN_START = '1;

  logic             run_q, idle_q, idle_d;
  logic [CNT_W-1:0] count_q, count_d;
  tmr_evt_t         evt_q, evt_d;

  logic             load, active, tick, pre_tick, ext_edge, at_limit;
  logic [CNT_W-1:0] start_val, step_val, next_val;

  assign start_val = dir_down_i ? DOWN_START : UP_START;
  // idle after reset and after a one-shot finishes; left by a rising run
  assign load      = run_i && !run_q && idle_q;
  assign active    = run_i && !idle_q;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (active && !cnt_mode_i),
    .clr_i  (load),
    .div_i  (prescale_i),
    .tick_o (pre_tick)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_i  (ext_i),
    .sel_i  (edge_sel_e'(edge_sel_i)),
    .edge_o (ext_edge)
  );

  assign tick     = cnt_mode_i ? (active && ext_edge) : pre_tick;
  assign at_limit = (count_q == limit_i);
  assign step_val = dir_down_i ? (count_q - CNT_W'(1)) : (count_q + CNT_W'(1));
  assign next_val = at_limit ? start_val : step_val;

  always_comb begin
    count_d = count_q;
    idle_d  = idle_q;
    evt_d   = '0;
    if (load) begin
      count_d = start_val;
      idle_d  = 1'b0;
    end else if (tick) begin
      count_d     = next_val;
      evt_d.match = (next_val == match_i);
      evt_d.ovf   = (next_val == limit_i);
      if (at_limit && one_shot_i) idle_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      idle_q  <= 1'b1;
      count_q <= '0;
      evt_q   <= '0;
    end else begin
      run_q   <= run_i;
      idle_q  <= idle_d;
      count_q <= count_d;
      evt_q   <= evt_d;
    end
  end

  tmr_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_d),
    .en_i     (irq_en_i),
    .clr_i    (irq_clr_i),
    .status_o (irq_status_o),
    .irq_o    (irq_o)
  );

  assign count_o     = count_q;
  assign match_evt_o = evt_q.match;
  assign ovf_evt_o   = evt_q.ovf;

  // R6: the match strobe is shown together with the count it matched
  assert_match_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt_o |-> (count_o == $past(match_i)));
  // R7: the overflow strobe is shown together with the limit count
  assert_ovf_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_o |-> (count_o == $past(limit_i)));
  // R10: a low run level freezes the count
  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(count_q));
  // R4: a finished one-shot holds while run stays high
  assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && run_q && run_i) |=> $stable(count_q));
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, cnt_mode, dir_down, one_shot, irq_clr, ext;
  logic [1:0]  edge_sel, irq_en;
  logic [5:0]  prescale;
  logic [31:0] match_v, limit_v;
  logic [31:0] count;
  logic        match_evt, ovf_evt, irq;
  logic [1:0]  irq_status;

  int n_chk = 0;
  int n_fail = 0;
  int m_cnt = 0;
  int o_cnt = 0;
  logic mon_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_channel u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .cnt_mode_i(cnt_mode),
    .dir_down_i(dir_down), .one_shot_i(one_shot), .edge_sel_i(edge_sel),
    .prescale_i(prescale), .match_i(match_v), .limit_i(limit_v),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr), .ext_i(ext),
    .count_o(count), .match_evt_o(match_evt), .ovf_evt_o(ovf_evt),
    .irq_status_o(irq_status), .irq_o(irq)
  );

  // strobe counter, sampled away from the active edge
  always @(negedge clk) begin
    if (!mon_en) begin
      m_cnt <= 0;
      o_cnt <= 0;
    end else begin
      if (match_evt) m_cnt <= m_cnt + 1;
      if (ovf_evt)   o_cnt <= o_cnt + 1;
    end
  end

  typedef struct packed {
    logic [5:0]  pre;
    logic [31:0] lim;
    logic [31:0] mat;
    logic        down;
    logic        oneshot;
    logic [31:0] n;
    logic [31:0] exp_cnt;
    logic [31:0] exp_m;
    logic [31:0] exp_o;
  } vec_t;

  // timer-mode runs: steps = n/(pre+1) after the start cycle
  localparam vec_t VECS [10] = '{
    '{6'd0,  32'd5,        32'd2,        1'b0, 1'b0, 32'd8,   32'd2,        32'd2, 32'd1}, // R2 wrap
    '{6'd2,  32'd12,       32'd2,        1'b0, 1'b0, 32'd30,  32'd10,       32'd1, 32'd0}, // R1
    '{6'd2,  32'd3,        32'd1,        1'b0, 1'b0, 32'd40,  32'd1,        32'd4, 32'd3}, // R1 periodic
    '{6'd0,  32'd4,        32'd7,        1'b0, 1'b0, 32'd12,  32'd2,        32'd0, 32'd2}, // R8
    '{6'd0,  32'hFFFFFFFC, 32'hFFFFFFFE, 1'b1, 1'b0, 32'd6,   32'hFFFFFFFD, 32'd2, 32'd1}, // R3
    '{6'd1,  32'd0,        32'd0,        1'b0, 1'b0, 32'd6,   32'd0,        32'd3, 32'd3}, // R7 limit 0
    '{6'd63, 32'd10,       32'd1,        1'b0, 1'b0, 32'd130, 32'd2,        32'd1, 32'd0}, // R1 max divide
    '{6'd1,  32'hFFFFFFFE, 32'hFFFFFFFF, 1'b1, 1'b0, 32'd9,   32'hFFFFFFFF, 32'd2, 32'd2}, // R3 R1
    '{6'd0,  32'd3,        32'd1,        1'b0, 1'b1, 32'd10,  32'd0,        32'd1, 32'd1}, // R4 up
    '{6'd0,  32'hFFFFFFFD, 32'd0,        1'b1, 1'b1, 32'd10,  32'hFFFFFFFF, 32'd0, 32'd1}  // R4 down
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    mon_en   = 1'b0;
    rst_n    = 1'b0;
    run      = 1'b0;
    irq_clr  = 1'b0;
    ext      = 1'b0;
    cnt_mode = 1'b0;
    dir_down = 1'b0;
    one_shot = 1'b0;
    edge_sel = 2'b00;
    irq_en   = 2'b11;
    prescale = '0;
    match_v  = '0;
    limit_v  = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ext_pulse();
    ext = 1'b1;
    repeat (6) @(negedge clk);
    ext = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R11: reset state
    do_reset();
    chk("R11 count", count, 32'd0);
    chk("R11 strobes", {30'd0, match_evt, ovf_evt}, 32'd0);
    chk("R11 status", {29'd0, irq, irq_status}, 32'd0);

    foreach (VECS[i]) begin
      string tc, tm;
      do_reset();
      prescale = VECS[i].pre;
      limit_v  = VECS[i].lim;
      match_v  = VECS[i].mat;
      dir_down = VECS[i].down;
      one_shot = VECS[i].oneshot;
      mon_en   = 1'b1;
      run      = 1'b1;
      @(posedge clk);
      repeat (VECS[i].n) @(posedge clk);
      @(negedge clk);
      #1;
      tc = VECS[i].oneshot ? "R4" : VECS[i].down ? "R3" : (VECS[i].pre != 0) ? "R1" : "R2";
      tm = (!VECS[i].down && VECS[i].mat > VECS[i].lim) ? "R8" : "R6";
      chk($sformatf("%s count vec%0d", tc, i), count, VECS[i].exp_cnt);
      chk($sformatf("%s match strobes vec%0d", tm, i), m_cnt, VECS[i].exp_m);
      chk($sformatf("R7 ovf strobes vec%0d", i), o_cnt, VECS[i].exp_o);
      chk($sformatf("R9 status vec%0d", i), {30'd0, irq_status},
          {30'd0, VECS[i].exp_o != 0, VECS[i].exp_m != 0});
    end

    // R10: freeze and resume without reload
    do_reset();
    limit_v = 32'd100;
    run = 1'b1;
    @(posedge clk);
    repeat (5) @(posedge clk);
    @(negedge clk); #1;
    chk("R10 count before freeze", count, 32'd5);
    run = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    chk("R10 count frozen", count, 32'd5);
    run = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R10 resume from held count", count, 32'd8);

    // R4: one-shot halt then restart
    do_reset();
    limit_v  = 32'd3;
    match_v  = 32'd1;
    one_shot = 1'b1;
    run      = 1'b1;
    @(posedge clk);
    repeat (15) @(posedge clk);
    @(negedge clk); #1;
    chk("R4 one-shot halted at start value", count, 32'd0);
    run = 1'b0;
    @(negedge clk);
    run = 1'b1;
    @(posedge clk);
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk("R4 one-shot restart", count, 32'd2);

    // R9: masked match, enabled overflow, clear
    do_reset();
    limit_v = 32'd2;
    match_v = 32'd1;
    irq_en  = 2'b10;
    run     = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R6 match strobe at count 1", {31'd0, match_evt}, 32'd1);
    chk("R9 masked match leaves status", {29'd0, irq, irq_status}, 32'd0);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R7 overflow strobe", {31'd0, ovf_evt}, 32'd1);
    chk("R9 overflow status and irq", {29'd0, irq, irq_status}, 32'b110);
    run = 1'b0;
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    #1;
    chk("R9 clear", {29'd0, irq, irq_status}, 32'd0);
    chk("R10 count held during clear", count, 32'd2);

    // R5: counter mode, edge selection, prescaler bypassed
    do_reset();
    cnt_mode = 1'b1;
    prescale = 6'd5;
    limit_v  = 32'd100;
    edge_sel = 2'b01;
    run      = 1'b1;
    repeat (3) @(negedge clk);
    repeat (3) ext_pulse();
    #1;
    chk("R5 rising edges", count, 32'd3);
    edge_sel = 2'b10;
    repeat (2) ext_pulse();
    #1;
    chk("R5 falling edges", count, 32'd5);
    edge_sel = 2'b11;
    repeat (2) ext_pulse();
    #1;
    chk("R5 both edges", count, 32'd9);
    edge_sel = 2'b00;
    repeat (2) ext_pulse();
    #1;
    chk("R5 no edge selected", count, 32'd9);

    summary();
  end
endmodule